// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the digital core of a byte-addressed serial EEPROM that answers on a two-wire bus. A fast system clock samples SCL and SDA; the block finds START and STOP conditions, receives bytes on rising SCL and changes its own SDA pull-down only while SCL is low. It never drives SDA high: its only output is an open-drain pull-down enable. A device select byte carries a fixed type code, a zero, two strap bits and the direction bit. Two address bytes then load the word address counter.

After the address, a write transfer gathers data bytes in a 64-byte page buffer and wraps within the current page. A STOP after at least one data byte starts a self-timed internal write cycle. During that cycle the buffered bytes are copied into the storage array, and the device ignores its select byte. A read transfer returns bytes from the word address counter, which advances after each byte the master acknowledges. A repeated START after the address bytes gives a random read. The write-protect input makes the whole array read-only.

The address width is a parameter, `ADDR_W`. Set it to 14 for the 16384-byte organisation. The default is smaller so the array stays modest. Straps and write-protect are plain logic inputs. Pads that may float must carry pull-downs, so an unconnected pin reads as zero.

Top module: `twi_eeprom_slave`

## Requirements
- R1: The select byte is acknowledged only when its bits 7..1 equal 1010, 0, strapA1, strapA0 (bit 0 is the direction, 1 = read); for any other value SDA is not pulled low in the acknowledge slot and the transfer is ignored until the next START.
- R2: While the internal write cycle runs, a matching select byte is not acknowledged.
- R3: A write select is followed by a high and a low address byte (high byte first); address bits at or above ADDR_W are ignored.
- R4: Data bytes are acknowledged and buffered. The low 6 address bits wrap within the current 64-byte page while the upper bits stay fixed. A STOP after at least one data byte commits the buffered bytes to the array.
- R5: With wpIn high, data bytes are still acknowledged. The STOP starts no write cycle, the array keeps its old contents, and the next select byte is acknowledged at once.
- R6: The write cycle lasts WRITE_CYCLES system clocks from the STOP. Afterwards the select byte is acknowledged again.
- R7: A repeated START and a read select byte after the address bytes returns the byte stored at the loaded address, most significant bit first.
- R8: During a read, the address advances by one after each byte the master acknowledges, and wraps from the last location to 0.
- R9: After the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next START.
- R10: The pull-down enable changes only while SCL is low, and SDA is only ever pulled low, never driven high.
- R11: A STOP after a write select and address bytes, with no data byte, starts no write cycle.
- R12: After reset, SDA is released and the first matching select byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| strapA0 | input | 1 | Device address strap, bit 0 |
| strapA1 | input | 1 | Device address strap, bit 1 |
| wpIn | input | 1 | Write protect, high makes the array read-only |
| sdaLow | output | 1 | Open-drain pull-down enable for SDA |

## Verification
The hardest state to reach from the ports is the edge of the self-timed write window. The bench must see a refused select byte shortly before the cycle ends and an accepted one shortly after, with the only observable being the acknowledge bit of a complete bus transfer. The stimulus issues a STOP that commits data, waits a computed number of clocks, and probes with a bare select plus STOP. The probe's acknowledge slot lands well inside the window the first time and past it the second. Random page writes of up to 20 bytes at random addresses are then read back through random reads checked against a bench memory model. Page wrap and wrap at the end of the array are reached with directed starting addresses.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } busState_e;

  typedef enum logic [1:0] {
    ROLE_DEV,
    ROLE_AHI,
    ROLE_ALO,
    ROLE_DATA
  } rxRole_e;

  // Strobes from the bus control to the storage datapath
  typedef struct packed {
    logic setAddrHi;
    logic setAddrLo;
    logic pushData;
    logic nextRead;
    logic startCommit;
  } dpStrobe_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/twi_bus_ctrl.sv
module twi_bus_ctrl
  import twi_eeprom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic       strapA0,
  input  logic       strapA1,
  input  logic       wpIn,
  input  logic       busyIn,
  input  logic [7:0] txByte,
  output logic       sdaLow,
  output logic [7:0] rxByte,
  output dpStrobe_t  strobe
);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclNow, sdaNow;
  logic       sclRise, sclFall, startCond, stopCond;

  busState_e  state;
  rxRole_e    role;
  logic [2:0] bitCnt;
  logic       byteDone;
  logic [7:0] shReg;
  logic [6:0] txSh;
  logic       ackGiven, txNext, mAck, gotData, sdaLowQ;
  logic       devMatch, ackNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], scl};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow    = sclSync[1];
  assign sdaNow    = sdaSync[1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startCond = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopCond  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  assign devMatch = (shReg[7:1] == {DEV_TYPE, 1'b0, strapA1, strapA0});
  assign ackNow   = (role == ROLE_DEV) ? (devMatch && !busyIn) : 1'b1;

  always_comb begin
    strobe = '0;
    if (state == ST_RX && sclFall && byteDone && !startCond && !stopCond) begin
      case (role)
        ROLE_AHI:  strobe.setAddrHi = 1'b1;
        ROLE_ALO:  strobe.setAddrLo = 1'b1;
        ROLE_DATA: strobe.pushData  = 1'b1;
        default:   ;
      endcase
    end
    strobe.nextRead    = (state == ST_TXACK) && sclRise && !sdaNow;
    strobe.startCommit = stopCond && gotData && !wpIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      role     <= ROLE_DEV;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      shReg    <= '0;
      txSh     <= '0;
      ackGiven <= 1'b0;
      txNext   <= 1'b0;
      mAck     <= 1'b0;
      gotData  <= 1'b0;
      sdaLowQ  <= 1'b0;
    end else if (startCond) begin
      state    <= ST_RX;
      role     <= ROLE_DEV;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      sdaLowQ  <= 1'b0;
      gotData  <= 1'b0;
    end else if (stopCond) begin
      state    <= ST_IDLE;
      sdaLowQ  <= 1'b0;
      gotData  <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && !byteDone) begin
            shReg  <= {shReg[6:0], sdaNow};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) byteDone <= 1'b1;
          end else if (sclFall && byteDone) begin
            state    <= ST_ACK;
            ackGiven <= ackNow;
            sdaLowQ  <= ackNow;
            txNext   <= 1'b0;
            case (role)
              ROLE_DEV: begin
                txNext <= shReg[0];
                if (!shReg[0]) role <= ROLE_AHI;
              end
              ROLE_AHI: role    <= ROLE_ALO;
              ROLE_ALO: role    <= ROLE_DATA;
              default:  gotData <= 1'b1;
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            sdaLowQ  <= 1'b0;
            bitCnt   <= '0;
            byteDone <= 1'b0;
            if (!ackGiven) begin
              state <= ST_IDLE;
            end else if (txNext) begin
              state   <= ST_TX;
              txSh    <= txByte[6:0];
              sdaLowQ <= ~txByte[7];
            end else begin
              state <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 3'd7) begin
              sdaLowQ <= 1'b0;
              state   <= ST_TXACK;
              mAck    <= 1'b0;
            end else begin
              sdaLowQ <= ~txSh[6];
              txSh    <= {txSh[5:0], 1'b0};
              bitCnt  <= bitCnt + 3'd1;
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            if (sdaNow) state <= ST_IDLE;
            else        mAck  <= 1'b1;
          end else if (sclFall && mAck) begin
            state   <= ST_TX;
            bitCnt  <= '0;
            txSh    <= txByte[6:0];
            sdaLowQ <= ~txByte[7];
            mAck    <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaLow = sdaLowQ;
  assign rxByte = shReg;

  // R10: the pull-down only moves while the sampled clock line is low
  assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sdaLowQ != $past(sdaLowQ)) |-> !sclNow);

  // R2: no acknowledge of a select byte while a write cycle runs
  assert_busy_nack_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK && role == ROLE_DEV && busyIn) |-> !sdaLowQ);

  // R9: nothing is driven once the transfer is abandoned
  assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaLowQ);

endmodule

// File: rtl/twi_eeprom_datapath.sv
module twi_eeprom_datapath
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic [7:0] rxByte,
  output logic [7:0] txByte,
  output logic       busy
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - 8;
  localparam int UPPER_W    = ADDR_W - PAGE_W;
  localparam int TMR_W      = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;

  logic [ADDR_W-1:0]     addrCnt;
  logic [HI_W-1:0]       hiHold;
  logic [7:0]            pageBuf [0:PAGE_BYTES-1];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [UPPER_W-1:0]    commitPage;
  logic [PAGE_W-1:0]     copyIdx;
  logic                  copying;
  logic [TMR_W-1:0]      timer;
  logic [7:0]            mem [0:DEPTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt    <= '0;
      hiHold     <= '0;
      pageValid  <= '0;
      commitPage <= '0;
      copyIdx    <= '0;
      copying    <= 1'b0;
      timer      <= '0;
      busy       <= 1'b0;
    end else begin
      if (strobe.setAddrHi) hiHold <= rxByte[HI_W-1:0];
      if (strobe.setAddrLo) begin
        addrCnt   <= {hiHold, rxByte};
        pageValid <= '0;
      end
      if (strobe.pushData) begin
        pageValid[addrCnt[PAGE_W-1:0]] <= 1'b1;
        addrCnt <= {addrCnt[ADDR_W-1:PAGE_W], addrCnt[PAGE_W-1:0] + 1'b1};
      end
      if (strobe.nextRead) addrCnt <= addrCnt + 1'b1;
      if (strobe.startCommit) begin
        busy       <= 1'b1;
        timer      <= '0;
        copying    <= 1'b1;
        copyIdx    <= '0;
        commitPage <= addrCnt[ADDR_W-1:PAGE_W];
      end else if (busy) begin
        timer <= timer + 1'b1;
        if (copying) begin
          copyIdx <= copyIdx + 1'b1;
          if (copyIdx == {PAGE_W{1'b1}}) copying <= 1'b0;
        end
        if (timer == TMR_W'(WRITE_CYCLES - 1)) begin
          busy      <= 1'b0;
          pageValid <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.pushData) pageBuf[addrCnt[PAGE_W-1:0]] <= rxByte;
    if (copying && pageValid[copyIdx]) mem[{commitPage, copyIdx}] <= pageBuf[copyIdx];
  end

  assign txByte = mem[addrCnt];

  // R4: a buffered byte never moves the address out of its page
  assert_page_stay_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.pushData) |-> (addrCnt[ADDR_W-1:PAGE_W] == $past(addrCnt[ADDR_W-1:PAGE_W])));

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sdaIn,
  input  logic strapA0,
  input  logic strapA1,
  input  logic wpIn,
  output logic sdaLow
);

  dpStrobe_t  strobe;
  logic [7:0] rxByte, txByte;
  logic       busy;

  twi_bus_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .scl    (scl),
    .sdaIn  (sdaIn),
    .strapA0(strapA0),
    .strapA1(strapA1),
    .wpIn   (wpIn),
    .busyIn (busy),
    .txByte (txByte),
    .sdaLow (sdaLow),
    .rxByte (rxByte),
    .strobe (strobe)
  );

  twi_eeprom_datapath #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .rxByte(rxByte),
    .txByte(txByte),
    .busy  (busy)
  );

  // R5: a write cycle never begins while the array is protected
  assert_wp_no_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(!wpIn));

endmodule

// File: tb/tb_twi_eeprom_slave.sv
`timescale 1ns/1ps
module tb_twi_eeprom_slave;
  localparam int AW    = 11;
  localparam int WC    = 1000;
  localparam int Q     = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, scl = 1'b1, mSda = 1'b1;
  logic strapA0 = 1'b0, strapA1 = 1'b1, wpIn = 1'b0;
  logic sdaLow, sdaBus;
  assign sdaBus = mSda & ~sdaLow;

  twi_eeprom_slave #(.ADDR_W(AW), .PAGE_W(6), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaBus),
    .strapA0(strapA0), .strapA1(strapA1), .wpIn(wpIn), .sdaLow(sdaLow));

  int checks = 0, fails = 0, edgeViol = 0;
  bit finished = 0;
  logic [7:0] refMem [0:DEPTH-1];
  bit refKnown [0:DEPTH-1];
  logic prevLow = 1'b0;

  // R10 monitor: the pull-down must not move while SCL is high
  always @(posedge clk) begin
    if (rstN && scl && sdaLow !== prevLow) edgeViol++;
    prevLow <= sdaLow;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] sel(input bit rd);
    return {4'b1010, 1'b0, strapA1, strapA0, rd};
  endfunction

  task automatic busStart;
    mSda = 1'b1; waitQ; scl = 1'b1; waitQ; mSda = 1'b0; waitQ; scl = 1'b0; waitQ;
  endtask

  task automatic busStop;
    mSda = 1'b0; waitQ; scl = 1'b1; waitQ; mSda = 1'b1; waitQ;
  endtask

  task automatic clockBit(input bit b, output bit s);
    mSda = b; waitQ; scl = 1'b1; waitQ; s = sdaBus; waitQ; scl = 1'b0; waitQ;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      b[i] = s;
    end
    clockBit(!ackIt, s);
  endtask

  // Bare select with direction write then STOP; returns acknowledge
  task automatic probe(output bit acked);
    busStart;
    sendByte(sel(1'b0), acked);
    busStop;
  endtask

  // R3 R4 R5: page write, model updated only when not protected
  task automatic writeTxn(input logic [15:0] a, input int len, input string req);
    bit ak;
    logic [7:0] d;
    logic [AW-1:0] idx;
    busStart;
    sendByte(sel(1'b0), ak); check(ak, {req, " select ack"}, ak, 1);
    sendByte(a[15:8], ak);   check(ak, "R3 high address ack", ak, 1);
    sendByte(a[7:0], ak);    check(ak, "R3 low address ack", ak, 1);
    for (int i = 0; i < len; i++) begin
      d = 8'($urandom);
      sendByte(d, ak);
      check(ak, {req, " data ack"}, ak, 1);
      idx = {a[AW-1:6], 6'(a[5:0] + i)};
      if (!wpIn) begin
        refMem[idx] = d;
        refKnown[idx] = 1'b1;
      end
    end
    busStop;
  endtask

  // R7 R8 R9: random read of len bytes from address a
  task automatic readTxn(input logic [15:0] a, input int len, input string req);
    bit ak, s;
    logic [7:0] d;
    logic [AW-1:0] idx;
    busStart;
    sendByte(sel(1'b0), ak); check(ak, "R7 write select ack", ak, 1);
    sendByte(a[15:8], ak);
    sendByte(a[7:0], ak);
    busStart;
    sendByte(sel(1'b1), ak); check(ak, "R7 read select ack", ak, 1);
    for (int i = 0; i < len; i++) begin
      recvByte(i != len - 1, d);
      idx = AW'(a[AW-1:0] + i);
      if (refKnown[idx]) check(d == refMem[idx], req, d, refMem[idx]);
    end
    clockBit(1'b1, s);
    check(s == 1'b1, "R9 released after master nack", s, 1);
    busStop;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      summary;
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [15:0] a;
    int len;
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < DEPTH; i++) refKnown[i] = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    check(sdaLow == 1'b0, "R12 released in reset", sdaLow, 0);
    rstN = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check(sdaLow == 1'b0, "R12 released after reset", sdaLow, 0);
    probe(ak); check(ak, "R12 first select ack", ak, 1);

    // R11: address-only write leaves the device ready
    busStart;
    sendByte(sel(1'b0), ak); sendByte(8'h00, ak); sendByte(8'h10, ak);
    busStop;
    probe(ak); check(ak, "R11 no cycle without data", ak, 1);

    // R4 R7: directed write and random read
    writeTxn(16'h0010, 4, "R4");
    repeat (WC + 20) @(posedge clk);
    readTxn(16'h0010, 4, "R7 random read data");

    // R2 R6: busy window edges
    writeTxn(16'h0200, 2, "R6");
    probe(ak); check(!ak, "R2 select refused while busy", ak, 0);
    repeat (WC - 700) @(posedge clk);
    probe(ak); check(!ak, "R6 still busy near end", ak, 0);
    repeat (300) @(posedge clk);
    probe(ak); check(ak, "R6 ready after cycle", ak, 1);
    readTxn(16'h0200, 2, "R6 committed data");

    // R1: strap mismatch and wrong fixed bits
    busStart; sendByte(sel(1'b0) ^ 8'h04, ak); busStop;
    check(!ak, "R1 wrong strapA1 nack", ak, 0);
    busStart; sendByte(sel(1'b0) ^ 8'h02, ak); busStop;
    check(!ak, "R1 wrong strapA0 nack", ak, 0);
    busStart; sendByte(sel(1'b0) | 8'h08, ak); busStop;
    check(!ak, "R1 bit3 set nack", ak, 0);
    busStart; sendByte(sel(1'b0) ^ 8'h40, ak); busStop;
    check(!ak, "R1 type code nack", ak, 0);
    strapA1 = 1'b0; strapA0 = 1'b1;
    probe(ak); check(ak, "R1 new strap match ack", ak, 1);
    strapA1 = 1'b1; strapA0 = 1'b0;

    // R5: protected write
    wpIn = 1'b1;
    writeTxn(16'h0010, 3, "R5");
    probe(ak); check(ak, "R5 no cycle when protected", ak, 1);
    wpIn = 1'b0;
    readTxn(16'h0010, 4, "R5 array unchanged");

    // R4: page wrap
    writeTxn(16'h0080 + 16'd60, 8, "R4");
    repeat (WC + 20) @(posedge clk);
    readTxn(16'h0080, 64, "R4 page wrap data");

    // R3: upper address bits ignored
    writeTxn(16'hF923, 3, "R3");
    repeat (WC + 20) @(posedge clk);
    readTxn(16'h0123, 3, "R3 upper bits ignored");
    readTxn(16'h5123, 3, "R3 upper bits ignored on read");

    // R8: sequential read wraps at the end of the array
    writeTxn(16'(DEPTH - 4), 4, "R8");
    repeat (WC + 20) @(posedge clk);
    writeTxn(16'h0000, 4, "R8");
    repeat (WC + 20) @(posedge clk);
    readTxn(16'(DEPTH - 4), 8, "R8 wrap to zero");

    // Random page writes and read-back
    for (int n = 0; n < 8; n++) begin
      a = 16'($urandom);
      len = 1 + int'($urandom % 20);
      writeTxn(a, len, "R4 random");
      repeat (WC + 20) @(posedge clk);
      readTxn(16'({a[AW-1:6], 6'(a[5:0] + $urandom % len)}), 1 + int'($urandom % 24), "R8 random read");
    end

    check(edgeViol == 0, "R10 pull-down moved with SCL high", edgeViol, 0);
    finished = 1;
    summary;
    $finish;
  end

endmodule